// File: doc/BRIEF.md
# Structured Vector Load/Store Micro-op Sequencer

This block sits behind the decoder of a vector core. It takes one decoded structured load or store, meaning a transfer that spreads interleaved memory data across two to four consecutive vector registers. It turns that macro-operation into an ordered stream of tagged micro-operations.

A load becomes a memory phase followed by a de-interleave phase. A store becomes an interleave phase followed by a memory phase. The two phases meet in a bank of temporary interleave registers. The block does no address arithmetic, memory access or data shuffling. It only decides which micro-op comes next and how that micro-op is tagged.

A descriptor is offered on a valid/ready pair. The sequencer takes it only when idle. It then presents one micro-op at a time on a second valid/ready pair, and it returns to idle after the final micro-op has been taken. Every micro-op carries these tags:
- a kind code;
- a target register, with a flag that says whether it is a temporary;
- its index within its phase;
- the register count;
- first, last and delayed-commit flags;
- the predicate, base and offset indices, copied unchanged.

Top module: `vlsc_cracker`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and err is 0. in_ready is 0 from the cycle after a descriptor is taken until the cycle after its last micro-op is handed off. A descriptor offered while busy is ignored.
- R2: A taken descriptor with register count n in 2..4 yields exactly 2n micro-ops. out_valid falls in the cycle after the last one is handed off.
- R3: For a load (in_store=0), micro-ops 0..n-1 have out_kind=0 (memory load) and out_tmp=1, with out_reg equal to the temporary number i. Here i is the index within the phase and the temporary bank starts at 0.
- R4: For a load, micro-ops n..2n-1 have out_kind=1 (de-interleave) and out_tmp=0, with out_reg=(in_vdst+i) mod 32, which wraps past register 31.
- R5: For a store, micro-ops 0..n-1 have out_kind=2 (interleave), and micro-ops n..2n-1 have out_kind=3 (memory store). Both phases have out_tmp=1 and out_reg equal to temporary number i.
- R6: out_first is 1 only on micro-op 0, and out_last is 1 only on micro-op 2n-1.
- R7: out_dly (delayed commit) is 1 on every micro-op except the last one, where it is 0.
- R8: Every micro-op carries out_sub=i, counting from 0 within each phase, and out_cnt=n. It also carries out_pred, out_base and out_offs equal to the taken descriptor's fields.
- R9: A descriptor taken with n outside 2..4 makes err 1 for exactly the following cycle. No micro-op is emitted for it, and in_ready stays 1.
- R10: While out_valid=1 and out_ready=0, out_valid and every micro-op field hold their values.
- R11: The first micro-op appears on out_valid in the cycle after the descriptor is taken. With out_ready held at 1, a new micro-op follows in each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Sequencer idle; descriptor taken on valid and ready |
| in_store | input | 1 | 1 = store, 0 = load |
| in_vdst | input | 5 | First architectural vector register of the group |
| in_pred | input | 4 | Governing predicate index |
| in_base | input | 5 | Base scalar register index |
| in_offs | input | 5 | Offset scalar register index |
| in_nregs | input | 3 | Register count, legal 2..4 |
| err | output | 1 | One-cycle pulse for an illegal register count |
| out_valid | output | 1 | Micro-op presented |
| out_ready | input | 1 | Consumer takes the micro-op |
| out_kind | output | 2 | 0 load-mem, 1 de-interleave, 2 interleave, 3 store-mem |
| out_tmp | output | 1 | out_reg names a temporary interleave register |
| out_reg | output | 5 | Target register number |
| out_sub | output | 2 | Index within the phase |
| out_cnt | output | 3 | Register count of the group |
| out_first | output | 1 | First micro-op of the macro-op |
| out_last | output | 1 | Last micro-op of the macro-op |
| out_dly | output | 1 | Delayed commit |
| out_pred | output | 4 | Predicate index copied through |
| out_base | output | 5 | Base index copied through |
| out_offs | output | 5 | Offset index copied through |

## Verification
Some rules are checked by the assertions on every cycle:
- in_ready stays low while a micro-op is presented;
- the whole micro-op holds under back-pressure;
- delayed commit is the inverse of last;
- the last micro-op has an index one below the count;
- err comes only while idle with nothing presented;
- a legal descriptor is followed at once by a first-flagged micro-op.

Only the bench's scenarios can show the rest: the exact order of kinds and targets across both phases, the wrap of destination numbering past 31, the total count of 2n, and that a descriptor offered while busy leaves the stream untouched.

// File: rtl/vlsc_pkg.sv
package vlsc_pkg;
  localparam int unsigned NUM_VREGS = 32;
  localparam int unsigned VREG_W    = $clog2(NUM_VREGS);
  localparam int unsigned PRED_W    = 4;
  localparam int unsigned XREG_W    = 5;
  localparam int unsigned MIN_REGS  = 2;
  localparam int unsigned MAX_REGS  = 4;
  localparam int unsigned CNT_W     = $clog2(MAX_REGS + 1);
  localparam int unsigned SUB_W     = $clog2(MAX_REGS);
  localparam int unsigned STEP_W    = $clog2(2 * MAX_REGS);
  localparam int unsigned TMP_BASE  = 0;

  typedef enum logic [1:0] {
    UOP_LDMEM = 2'd0,
    UOP_DEINT = 2'd1,
    UOP_INTLV = 2'd2,
    UOP_STMEM = 2'd3
  } uop_kind_e;

  typedef struct packed {
    logic              is_store;
    logic [VREG_W-1:0] vdst;
    logic [PRED_W-1:0] pred;
    logic [XREG_W-1:0] base;
    logic [XREG_W-1:0] offs;
    logic [CNT_W-1:0]  nregs;
  } macro_t;

  typedef struct packed {
    uop_kind_e         kind;
    logic              tmp;
    logic [VREG_W-1:0] reg_idx;
    logic [SUB_W-1:0]  sub;
    logic [CNT_W-1:0]  cnt;
    logic              first;
    logic              last;
    logic              dly;
    logic [PRED_W-1:0] pred;
    logic [XREG_W-1:0] base;
    logic [XREG_W-1:0] offs;
  } uop_t;
endpackage

// File: rtl/vlsc_intake.sv
module vlsc_intake
  import vlsc_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   accept,
  input  macro_t desc_i,
  output logic   legal,
  output macro_t desc_q,
  output logic   err_q
);
  always_comb begin
    legal = (desc_i.nregs >= CNT_W'(MIN_REGS)) && (desc_i.nregs <= CNT_W'(MAX_REGS));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      desc_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= accept && !legal;
      if (accept && legal) desc_q <= desc_i;
    end
  end
endmodule

// File: rtl/vlsc_stepper.sv
module vlsc_stepper
  import vlsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              adv,
  input  logic [STEP_W-1:0] last_step,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              at_end
);
  assign at_end = (step == last_step);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start) begin
      busy <= 1'b1;
      step <= '0;
    end else if (adv) begin
      if (at_end) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + STEP_W'(1);
      end
    end
  end
endmodule

// File: rtl/vlsc_tagger.sv
module vlsc_tagger
  import vlsc_pkg::*;
(
  input  macro_t            desc,
  input  logic [STEP_W-1:0] step,
  output uop_t              uop
);
  logic [STEP_W:0]   n_w, s_w, i_w, last_w;
  logic              phase1;
  logic [SUB_W-1:0]  idx;
  logic [VREG_W-1:0] arch_reg, tmp_reg;

  always_comb begin
    n_w    = (STEP_W+1)'(desc.nregs);
    s_w    = (STEP_W+1)'(step);
    phase1 = (s_w >= n_w);
    i_w    = phase1 ? (s_w - n_w) : s_w;
    idx    = SUB_W'(i_w);
    last_w = (n_w << 1) - (STEP_W+1)'(1);
    tmp_reg = VREG_W'(TMP_BASE) + VREG_W'(idx);
  end

  generate
    if ((1 << VREG_W) == NUM_VREGS) begin : g_wrap_pow2
      assign arch_reg = desc.vdst + VREG_W'(idx);
    end else begin : g_wrap_mod
      assign arch_reg = VREG_W'((32'(desc.vdst) + 32'(idx)) % NUM_VREGS);
    end
  endgenerate

  always_comb begin
    uop       = '0;
    uop.sub   = idx;
    uop.cnt   = desc.nregs;
    uop.first = (s_w == '0);
    uop.last  = (s_w == last_w);
    uop.dly   = (s_w != last_w);
    uop.pred  = desc.pred;
    uop.base  = desc.base;
    uop.offs  = desc.offs;
    case ({desc.is_store, phase1})
      2'b00:   begin uop.kind = UOP_LDMEM; uop.tmp = 1'b1; uop.reg_idx = tmp_reg;  end
      2'b01:   begin uop.kind = UOP_DEINT; uop.tmp = 1'b0; uop.reg_idx = arch_reg; end
      2'b10:   begin uop.kind = UOP_INTLV; uop.tmp = 1'b1; uop.reg_idx = tmp_reg;  end
      default: begin uop.kind = UOP_STMEM; uop.tmp = 1'b1; uop.reg_idx = tmp_reg;  end
    endcase
  end
endmodule

// File: rtl/vlsc_cracker.sv
module vlsc_cracker
  import vlsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_store,
  input  logic [VREG_W-1:0] in_vdst,
  input  logic [PRED_W-1:0] in_pred,
  input  logic [XREG_W-1:0] in_base,
  input  logic [XREG_W-1:0] in_offs,
  input  logic [CNT_W-1:0]  in_nregs,
  output logic              err,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [1:0]        out_kind,
  output logic              out_tmp,
  output logic [VREG_W-1:0] out_reg,
  output logic [SUB_W-1:0]  out_sub,
  output logic [CNT_W-1:0]  out_cnt,
  output logic              out_first,
  output logic              out_last,
  output logic              out_dly,
  output logic [PRED_W-1:0] out_pred,
  output logic [XREG_W-1:0] out_base,
  output logic [XREG_W-1:0] out_offs
);
  macro_t            desc_in, desc_q, desc_sel;
  logic              legal, accept, start, adv, busy, at_end;
  logic [STEP_W-1:0] step, step_sel, last_step;
  logic [STEP_W:0]   total;
  uop_t              uop_next, uop_q;
  logic              valid_q;

  assign desc_in  = '{is_store: in_store, vdst: in_vdst, pred: in_pred,
                      base: in_base, offs: in_offs, nregs: in_nregs};
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;
  assign start    = accept && legal;
  assign adv      = valid_q && out_ready;

  assign total     = (STEP_W+1)'(desc_q.nregs) << 1;
  assign last_step = STEP_W'(total - (STEP_W+1)'(1));
  assign desc_sel  = start ? desc_in : desc_q;
  assign step_sel  = start ? '0 : (step + STEP_W'(1));

  vlsc_intake u_intake (
    .clk(clk), .rst(rst), .accept(accept), .desc_i(desc_in),
    .legal(legal), .desc_q(desc_q), .err_q(err)
  );

  vlsc_stepper u_stepper (
    .clk(clk), .rst(rst), .start(start), .adv(adv), .last_step(last_step),
    .busy(busy), .step(step), .at_end(at_end)
  );

  vlsc_tagger u_tagger (
    .desc(desc_sel), .step(step_sel), .uop(uop_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      uop_q   <= '0;
    end else if (start) begin
      valid_q <= 1'b1;
      uop_q   <= uop_next;
    end else if (adv) begin
      if (at_end) valid_q <= 1'b0;
      else        uop_q   <= uop_next;
    end
  end

  assign out_valid = valid_q;
  assign out_kind  = uop_q.kind;
  assign out_tmp   = uop_q.tmp;
  assign out_reg   = uop_q.reg_idx;
  assign out_sub   = uop_q.sub;
  assign out_cnt   = uop_q.cnt;
  assign out_first = uop_q.first;
  assign out_last  = uop_q.last;
  assign out_dly   = uop_q.dly;
  assign out_pred  = uop_q.pred;
  assign out_base  = uop_q.base;
  assign out_offs  = uop_q.offs;
endmodule

// File: rtl/vlsc_checker.sv
module vlsc_checker
  import vlsc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_store,
  input logic [VREG_W-1:0] in_vdst,
  input logic [PRED_W-1:0] in_pred,
  input logic [XREG_W-1:0] in_base,
  input logic [XREG_W-1:0] in_offs,
  input logic [CNT_W-1:0]  in_nregs,
  input logic              err,
  input logic              out_valid,
  input logic              out_ready,
  input logic [1:0]        out_kind,
  input logic              out_tmp,
  input logic [VREG_W-1:0] out_reg,
  input logic [SUB_W-1:0]  out_sub,
  input logic [CNT_W-1:0]  out_cnt,
  input logic              out_first,
  input logic              out_last,
  input logic              out_dly,
  input logic [PRED_W-1:0] out_pred,
  input logic [XREG_W-1:0] out_base,
  input logic [XREG_W-1:0] out_offs
);
  logic in_legal;
  assign in_legal = (in_nregs >= CNT_W'(MIN_REGS)) && (in_nregs <= CNT_W'(MAX_REGS));

  p_busy_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_reg)
      && $stable(out_tmp) && $stable(out_sub) && $stable(out_cnt) && $stable(out_first)
      && $stable(out_last) && $stable(out_dly) && $stable(out_pred)
      && $stable(out_base) && $stable(out_offs)));

  p_dly_r7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_dly == !out_last));

  p_first_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_first) |-> (out_sub == '0 && (out_kind == 2'd0 || out_kind == 2'd2)));

  p_last_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_last) |-> ((CNT_W'(out_sub) + CNT_W'(1)) == out_cnt));

  p_cnt_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_cnt >= CNT_W'(MIN_REGS) && out_cnt <= CNT_W'(MAX_REGS)));

  p_err_r9: assert property (@(posedge clk) disable iff (rst)
    err |-> (!out_valid && in_ready));

  p_start_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_legal) |=> (out_valid && out_first));
endmodule

bind vlsc_cracker vlsc_checker u_chk (.*);

// File: tb/sim_vlsc_cracker.sv
module sim_vlsc_cracker;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NVEC       = 8;
  // {store, vdst[4:0], nregs[2:0], stall}
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b0, 5'd3,  3'd2, 1'b0},
    {1'b0, 5'd10, 3'd3, 1'b1},
    {1'b0, 5'd30, 3'd4, 1'b0},
    {1'b1, 5'd5,  3'd2, 1'b0},
    {1'b1, 5'd31, 3'd3, 1'b1},
    {1'b1, 5'd0,  3'd4, 1'b0},
    {1'b0, 5'd31, 3'd2, 1'b1},
    {1'b1, 5'd17, 3'd4, 1'b1}
  };

  logic clk = 0, rst = 1;
  logic in_valid = 0, in_store = 0, out_ready = 1;
  logic [4:0] in_vdst = 0, in_base = 0, in_offs = 0, out_reg, out_base, out_offs;
  logic [3:0] in_pred = 0, out_pred;
  logic [2:0] in_nregs = 0, out_cnt;
  logic [1:0] out_kind, out_sub;
  logic in_ready, err, out_valid, out_tmp, out_first, out_last, out_dly;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlsc_cracker u0 (.*);

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic offer(input bit st, input logic [4:0] vd, input logic [2:0] n,
                       input logic [3:0] pr, input logic [4:0] ba, input logic [4:0] of);
    in_valid = 1; in_store = st; in_vdst = vd; in_nregs = n;
    in_pred = pr; in_base = ba; in_offs = of;
  endtask

  task automatic run_macro(input bit st, input logic [4:0] vd, input logic [2:0] n,
                           input bit stall, input bit poke);
    logic [3:0] pr = 4'(vd + 1);
    logic [4:0] ba = 5'(vd ^ 5'h15), of = 5'(n + 7);
    @(negedge clk);
    chk(in_ready == 1, "R1 ready idle", 32'(in_ready), 1);
    offer(st, vd, n, pr, ba, of);
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1, "R11 first uop next cycle", 32'(out_valid), 1);
    for (int s = 0; s < 2 * int'(n); s++) begin
      int i = (s < int'(n)) ? s : s - int'(n);
      logic [1:0] ek;
      logic       et;
      logic [4:0] er;
      logic [11:0] snap;
      if (!st) begin
        ek = (s < int'(n)) ? 2'd0 : 2'd1;
        et = (s < int'(n));
        er = (s < int'(n)) ? 5'(i) : 5'((int'(vd) + i) % 32);
      end else begin
        ek = (s < int'(n)) ? 2'd2 : 2'd3;
        et = 1;
        er = 5'(i);
      end
      if (poke && s == 1) offer(!st, 5'd9, 3'd3, 4'hF, 5'd1, 5'd2);
      if (stall && s == 1) begin
        out_ready = 0;
        snap = {out_kind, out_tmp, out_reg, out_sub, out_first, out_last};
        @(negedge clk);
        chk(out_valid == 1 && snap == {out_kind, out_tmp, out_reg, out_sub, out_first, out_last},
            "R10 hold under stall", 32'(snap), 32'({out_kind, out_tmp, out_reg, out_sub, out_first, out_last}));
        out_ready = 1;
      end
      if (poke && s == 1) in_valid = 0;
      chk(out_valid == 1, "R2 uop present", 32'(out_valid), 1);
      chk(in_ready == 0, "R1 busy not ready", 32'(in_ready), 0);
      chk({out_kind, out_tmp, out_reg} == {ek, et, er}, st ? "R5 store kind/target" :
          ((s < int'(n)) ? "R3 load mem kind/target" : "R4 load deint kind/target"),
          32'({out_kind, out_tmp, out_reg}), 32'({ek, et, er}));
      chk({out_first, out_last} == {s == 0, s == 2 * int'(n) - 1}, "R6 first/last",
          32'({out_first, out_last}), 32'({s == 0, s == 2 * int'(n) - 1}));
      chk(out_dly == (s != 2 * int'(n) - 1), "R7 delayed commit", 32'(out_dly), 32'(s != 2 * int'(n) - 1));
      chk({out_sub, out_cnt, out_pred, out_base, out_offs} == {2'(i), n, pr, ba, of}, "R8 sub/cnt/pass",
          32'({out_sub, out_cnt, out_pred, out_base, out_offs}), 32'({2'(i), n, pr, ba, of}));
      @(negedge clk);
    end
    chk(out_valid == 0, "R2 stream ends after 2n", 32'(out_valid), 0);
    chk(in_ready == 1, "R1 ready after last", 32'(in_ready), 1);
  endtask

  task automatic bad_count(input logic [2:0] n);
    @(negedge clk);
    offer(0, 5'd4, n, 4'd1, 5'd2, 5'd3);
    @(negedge clk);
    in_valid = 0;
    chk(err == 1, "R9 err pulse", 32'(err), 1);
    chk(out_valid == 0 && in_ready == 1, "R9 nothing emitted", 32'({out_valid, in_ready}), 32'(2'b01));
    @(negedge clk);
    chk(err == 0, "R9 err one cycle", 32'(err), 0);
    chk(out_valid == 0, "R9 still silent", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1 && out_valid == 0 && err == 0, "R1 reset state",
        32'({in_ready, out_valid, err}), 32'(3'b100));
    rst = 0;
    for (int k = 0; k < NVEC; k++)
      run_macro(VEC[k][9], VEC[k][8:4], VEC[k][3:1], VEC[k][0], 1'b0);
    // descriptor offered mid-sequence must not disturb the stream
    run_macro(1'b0, 5'd29, 3'd4, 1'b0, 1'b1);
    run_macro(1'b1, 5'd12, 3'd3, 1'b1, 1'b1);
    bad_count(3'd0);
    bad_count(3'd1);
    bad_count(3'd5);
    bad_count(3'd7);
    // legal descriptor right after an illegal one
    run_macro(1'b0, 5'd7, 3'd3, 1'b0, 1'b0);
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule